// File: doc/BRIEF.md
# FPGA Configuration Sequencer

This block walks a target programmable-logic fabric through one complete configuration cycle in hardware. A single start strobe launches it. On that strobe it checks the word alignment of the bitstream address. It then latches the interface width and the clock-to-data ratio decoded from a 4-bit mode-select input. After that it steps the configuration lines through a fixed sequence: enable, drive, reset, configure, stream, clock out and hand over. At each step it waits for the fabric's phase status to move on.

Every wait has a limit of `TIMEOUT` clock cycles. Each place where the run can fail reports its own 4-bit error code. A run ends with a one-cycle `done` pulse. An error code of zero means the fabric reached user mode. Any other code means the sequencer stopped there and returned to idle with every drive output released.

The bitstream data mover and the fabric itself sit outside this block. The mover is told to stream through `data_en` and answers with `xfer_done`. A separate clock generator takes the `dclk_req`/`dclk_cnt` burst requests and answers with `dclk_done`.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: On an accepted start, `cfg_wide` takes `msel[3]` (1 = 32-bit, 0 = 16-bit). It then holds, together with `cd_ratio`, until the next accepted start. `msel[2]` has no effect.
- R2: With `msel[3]`=1, `msel[1:0]` values 0, 1 and 2 give `cd_ratio` 0, 2 and 3. The `cd_ratio` encoding is 0=x1, 1=x2, 2=x4, 3=x8.
- R3: With `msel[3]`=0, `msel[1:0]` values 0, 1 and 2 give `cd_ratio` 0, 1 and 2. The value 3 gives `cd_ratio` 0 at either width.
- R4: A start whose `start_addr` has either of bits [1:0] set is refused. `done` pulses on the next cycle with `err`=1, `busy` never rises, and no drive output changes.
- R5: An accepted run first pulls `nce` low. One cycle later it raises `drive_en`, and one cycle after that it raises `nconfig_pull`. The pull holds until `phase` reads 1 (reset phase). The `phase` encoding is 1=reset, 2=configuration, 3=init, 4=user, others=none.
- R6: After the reset phase the pull drops and the sequencer waits for `phase`=2. It then drives `irq_clear` to all 12 ones for exactly one cycle, and raises `data_en` on the next cycle.
- R7: `data_en` holds until `xfer_done`. One cycle later, if neither `cfg_done` nor `nstatus` is high, the run ends with `err`=4. Otherwise `data_en` drops.
- R8: Next, `dclk_req` is raised with `dclk_cnt`=`INIT_PULSES` until `dclk_done`. The sequencer then waits for `phase` 3 or 4.
- R9: A second burst with `dclk_cnt`=`USER_PULSES` follows. The sequencer then waits for `phase`=4 and ends with `err`=0 and `drive_en` released.
- R10: Each wait gives up after `TIMEOUT` cycles with its own code: 2 reset, 3 configuration, 5 transfer, 6 first burst, 7 init, 8 second burst, 9 user. A reset-phase timeout keeps `busy` high for exactly `TIMEOUT`+2 cycles.
- R11: `done` lasts one cycle and coincides with `busy` low and every drive output released (`nce` high). `err` holds its value until the next accepted start.
- R12: A start strobe while `busy` is high is ignored.
- R13: After reset the block is idle: `busy`, `done`, `err`, `drive_en`, `nconfig_pull`, `data_en`, `irq_clear` and `dclk_req` are zero, and `nce` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, one cycle |
| start_addr | input | ADDR_W | Bitstream start address, checked for word alignment |
| msel | input | 4 | Mode-select pins |
| phase | input | 3 | Fabric phase status (1 reset, 2 config, 3 init, 4 user) |
| xfer_done | input | 1 | Data mover finished streaming |
| cfg_done | input | 1 | Fabric config-done line |
| nstatus | input | 1 | Fabric status line |
| dclk_done | input | 1 | Extra clock burst finished |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err | output | 4 | Result code, 0 = success |
| cfg_wide | output | 1 | 1 = 32-bit, 0 = 16-bit data width |
| cd_ratio | output | 2 | Clock-to-data ratio (0 x1, 1 x2, 2 x4, 3 x8) |
| nce | output | 1 | Active-low chip enable |
| drive_en | output | 1 | Configuration line drive enable |
| nconfig_pull | output | 1 | Holds the fabric in reset |
| data_en | output | 1 | Data path enable for the mover |
| irq_clear | output | 12 | One-cycle clear of the monitor interrupt bits |
| dclk_req | output | 1 | Extra clock burst request |
| dclk_cnt | output | DCLK_W | Pulse count of the requested burst |

## Verification
The bench builds the block with `TIMEOUT`=40, `INIT_PULSES`=4, `USER_PULSES`=12 and an 8-bit address. The short limit makes each of the seven timeouts reachable in a few dozen cycles, and the exact busy length of a reset timeout can be counted. The short second burst lets all sixteen mode-select values run to user mode in one sweep. A reactive fabric stub can withhold any single answer, so every error path and both init-phase exits are driven through the ports.

// File: rtl/cfg_seq_pkg.sv
// Shared encodings for the configuration sequencer: states, phase
// status codes, result codes and clock-to-data ratio codes.
package cfg_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_CE, S_DRV, S_WRST, S_WCFG, S_CLRI,
        S_XFER, S_CHK, S_BST1, S_WINIT, S_BST2, S_WUSER
    } seq_state_t;

    localparam logic [2:0] PH_RESET = 3'd1;
    localparam logic [2:0] PH_CFG   = 3'd2;
    localparam logic [2:0] PH_INIT  = 3'd3;
    localparam logic [2:0] PH_USER  = 3'd4;

    localparam logic [3:0] E_OK      = 4'd0;
    localparam logic [3:0] E_ALIGN   = 4'd1;
    localparam logic [3:0] E_TO_RST  = 4'd2;
    localparam logic [3:0] E_TO_CFG  = 4'd3;
    localparam logic [3:0] E_CFG_ERR = 4'd4;
    localparam logic [3:0] E_TO_XFER = 4'd5;
    localparam logic [3:0] E_TO_BST1 = 4'd6;
    localparam logic [3:0] E_TO_INIT = 4'd7;
    localparam logic [3:0] E_TO_BST2 = 4'd8;
    localparam logic [3:0] E_TO_USER = 4'd9;

    localparam logic [1:0] RATIO_X1 = 2'd0;
    localparam logic [1:0] RATIO_X2 = 2'd1;
    localparam logic [1:0] RATIO_X4 = 2'd2;
    localparam logic [1:0] RATIO_X8 = 2'd3;

    localparam int IRQ_W = 12;

endpackage

// File: rtl/cfg_mode_decode.sv
// Mode-select decoder. Purely combinational.
// Assumes msel is stable when the sequencer samples it at start.
// Bit 3 picks the width; bits [1:0] pick the ratio; bit 2 is unused.
module cfg_mode_decode
    import cfg_seq_pkg::*;
(
    input  logic [3:0] msel,
    output logic       wide,
    output logic [1:0] ratio
);

    // Map the select pins to width and clock-to-data ratio.
    always_comb begin
        wide = msel[3];
        casez (msel)
            4'b1?01: ratio = RATIO_X4;
            4'b1?10: ratio = RATIO_X8;
            4'b0?01: ratio = RATIO_X2;
            4'b0?10: ratio = RATIO_X4;
            default: ratio = RATIO_X1;
        endcase
    end

endmodule

// File: rtl/cfg_wait_timer.sv
// Wait-limit counter. Cleared on every state change of the sequencer,
// it counts up and saturates; expired is high once TIMEOUT cycles have
// been spent in the current state. Assumes TIMEOUT >= 2.
module cfg_wait_timer #(
    parameter int TIMEOUT = 32'h0100_0000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);

    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] LIMIT = TW'(TIMEOUT - 1);

    logic [TW-1:0] cnt;

    // Count cycles spent in the current state, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)   cnt <= '0;
        else if (cnt != LIMIT) cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LIMIT);

endmodule

// File: rtl/cfg_seq_fsm.sv
// Sequencing state machine. Steps through the configuration phases,
// decodes outputs from the state (Moore) and registers done/err.
// Assumes the timer is cleared whenever the state changes.
module cfg_seq_fsm
    import cfg_seq_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DCLK_W      = 16,
    parameter int INIT_PULSES = 4,
    parameter int USER_PULSES = 32'h5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              dec_wide,
    input  logic [1:0]        dec_ratio,
    input  logic [2:0]        phase,
    input  logic              xfer_done,
    input  logic              cfg_done,
    input  logic              nstatus,
    input  logic              dclk_done,
    input  logic              tmo,
    output logic              tmr_clr,
    output logic              busy,
    output logic              done,
    output logic [3:0]        err,
    output logic              cfg_wide,
    output logic [1:0]        cd_ratio,
    output logic              nce,
    output logic              drive_en,
    output logic              nconfig_pull,
    output logic              data_en,
    output logic [IRQ_W-1:0]  irq_clear,
    output logic              dclk_req,
    output logic [DCLK_W-1:0] dclk_cnt
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(3);

    seq_state_t state, nxt;
    logic       fin;
    logic [3:0] code;
    logic       accept;

    // Next state, end-of-run flag and result code.
    always_comb begin
        nxt    = state;
        fin    = 1'b0;
        code   = E_OK;
        accept = 1'b0;
        case (state)
            S_IDLE: if (start) begin
                if ((start_addr & ALIGN_MASK) != '0) begin
                    fin  = 1'b1;
                    code = E_ALIGN;
                end else begin
                    accept = 1'b1;
                    nxt    = S_CE;
                end
            end
            S_CE:   nxt = S_DRV;
            S_DRV:  nxt = S_WRST;
            S_WRST: if (phase == PH_RESET) nxt = S_WCFG;
                    else if (tmo) begin fin = 1'b1; code = E_TO_RST; end
            S_WCFG: if (phase == PH_CFG) nxt = S_CLRI;
                    else if (tmo) begin fin = 1'b1; code = E_TO_CFG; end
            S_CLRI: nxt = S_XFER;
            S_XFER: if (xfer_done) nxt = S_CHK;
                    else if (tmo) begin fin = 1'b1; code = E_TO_XFER; end
            S_CHK:  if (cfg_done || nstatus) nxt = S_BST1;
                    else begin fin = 1'b1; code = E_CFG_ERR; end
            S_BST1: if (dclk_done) nxt = S_WINIT;
                    else if (tmo) begin fin = 1'b1; code = E_TO_BST1; end
            S_WINIT: if (phase == PH_INIT || phase == PH_USER) nxt = S_BST2;
                    else if (tmo) begin fin = 1'b1; code = E_TO_INIT; end
            S_BST2: if (dclk_done) nxt = S_WUSER;
                    else if (tmo) begin fin = 1'b1; code = E_TO_BST2; end
            S_WUSER: if (phase == PH_USER) fin = 1'b1;
                    else if (tmo) begin fin = 1'b1; code = E_TO_USER; end
            default: nxt = S_IDLE;
        endcase
        if (fin) nxt = S_IDLE;
    end

    // State, result and latched mode registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            done     <= 1'b0;
            err      <= E_OK;
            cfg_wide <= 1'b0;
            cd_ratio <= RATIO_X1;
        end else begin
            state <= nxt;
            done  <= fin;
            if (fin) err <= code;
            else if (accept) err <= E_OK;
            if (accept) begin
                cfg_wide <= dec_wide;
                cd_ratio <= dec_ratio;
            end
        end
    end

    assign tmr_clr = (nxt != state);

    // Drive outputs decoded from the current state.
    always_comb begin
        busy         = (state != S_IDLE);
        nce          = (state == S_IDLE);
        drive_en     = !(state inside {S_IDLE, S_CE});
        nconfig_pull = (state == S_WRST);
        data_en      = (state == S_XFER) || (state == S_CHK);
        irq_clear    = (state == S_CLRI) ? {IRQ_W{1'b1}} : '0;
        dclk_req     = (state == S_BST1) || (state == S_BST2);
        if (state == S_BST1)      dclk_cnt = DCLK_W'(INIT_PULSES);
        else if (state == S_BST2) dclk_cnt = DCLK_W'(USER_PULSES);
        else                      dclk_cnt = '0;
    end

endmodule

// File: rtl/cfg_seq_ctrl.sv
// Top of the configuration sequencer: mode decoder, wait timer and
// state machine. Assumes all inputs are synchronous to clk.
module cfg_seq_ctrl
    import cfg_seq_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DCLK_W      = 16,
    parameter int TIMEOUT     = 32'h0100_0000,
    parameter int INIT_PULSES = 4,
    parameter int USER_PULSES = 32'h5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [3:0]        msel,
    input  logic [2:0]        phase,
    input  logic              xfer_done,
    input  logic              cfg_done,
    input  logic              nstatus,
    input  logic              dclk_done,
    output logic              busy,
    output logic              done,
    output logic [3:0]        err,
    output logic              cfg_wide,
    output logic [1:0]        cd_ratio,
    output logic              nce,
    output logic              drive_en,
    output logic              nconfig_pull,
    output logic              data_en,
    output logic [11:0]       irq_clear,
    output logic              dclk_req,
    output logic [DCLK_W-1:0] dclk_cnt
);

    logic       dec_wide;
    logic [1:0] dec_ratio;
    logic       tmr_clr;
    logic       tmo;

    cfg_mode_decode u_dec (
        .msel  (msel),
        .wide  (dec_wide),
        .ratio (dec_ratio)
    );

    cfg_wait_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .expired (tmo)
    );

    cfg_seq_fsm #(
        .ADDR_W      (ADDR_W),
        .DCLK_W      (DCLK_W),
        .INIT_PULSES (INIT_PULSES),
        .USER_PULSES (USER_PULSES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .start_addr   (start_addr),
        .dec_wide     (dec_wide),
        .dec_ratio    (dec_ratio),
        .phase        (phase),
        .xfer_done    (xfer_done),
        .cfg_done     (cfg_done),
        .nstatus      (nstatus),
        .dclk_done    (dclk_done),
        .tmo          (tmo),
        .tmr_clr      (tmr_clr),
        .busy         (busy),
        .done         (done),
        .err          (err),
        .cfg_wide     (cfg_wide),
        .cd_ratio     (cd_ratio),
        .nce          (nce),
        .drive_en     (drive_en),
        .nconfig_pull (nconfig_pull),
        .data_en      (data_en),
        .irq_clear    (irq_clear),
        .dclk_req     (dclk_req),
        .dclk_cnt     (dclk_cnt)
    );

endmodule

// File: rtl/cfg_seq_chk.sv
// Protocol checker for the configuration sequencer, bound to the top.
// Assumes synchronous active-low reset; all properties are off in reset.
module cfg_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ADDR_W-1:0] start_addr,
    input logic              busy,
    input logic              done,
    input logic [3:0]        err,
    input logic              cfg_wide,
    input logic [1:0]        cd_ratio,
    input logic              nce,
    input logic              drive_en,
    input logic              nconfig_pull,
    input logic              data_en,
    input logic [11:0]       irq_clear,
    input logic              dclk_req
);

    assert_mode_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(cfg_wide) && $stable(cd_ratio)));

    assert_narrow_ratio_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_wide) |-> (cd_ratio != 2'd3));

    assert_align_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (start_addr[1:0] != 2'b00)) |=> (done && err == 4'd1 && !busy));

    assert_pull_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nconfig_pull |-> (drive_en && !nce));

    assert_drive_after_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en) |-> !$past(nce));

    assert_clear_then_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clear != 12'd0) |=> (data_en && irq_clear == 12'd0));

    assert_data_needs_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        data_en |-> (drive_en && !nconfig_pull && !dclk_req));

    assert_burst_needs_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_req |-> (drive_en && !data_en));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_released_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && nce && !drive_en && !nconfig_pull && !data_en && !dclk_req));

endmodule

bind cfg_seq_ctrl cfg_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .start_addr   (start_addr),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .cfg_wide     (cfg_wide),
    .cd_ratio     (cd_ratio),
    .nce          (nce),
    .drive_en     (drive_en),
    .nconfig_pull (nconfig_pull),
    .data_en      (data_en),
    .irq_clear    (irq_clear),
    .dclk_req     (dclk_req)
);

// File: tb/sim_cfg_seq_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_seq_ctrl;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int TO = 40;
    localparam int IP = 4;
    localparam int UP = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [3:0]    msel = '0;
    logic [2:0]    phase;
    logic          xfer_done, cfg_done, nstatus, dclk_done;
    logic          busy, done, cfg_wide, nce, drive_en, nconfig_pull, data_en, dclk_req;
    logic [3:0]    err;
    logic [1:0]    cd_ratio;
    logic [11:0]   irq_clear;
    logic [DW-1:0] dclk_cnt;

    int n_chk = 0;
    int n_err = 0;
    int stall = 0;
    bit init_user = 1'b0;

    always #2 clk = ~clk;

    cfg_seq_ctrl #(.ADDR_W(AW), .DCLK_W(DW), .TIMEOUT(TO),
                   .INIT_PULSES(IP), .USER_PULSES(UP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .msel(msel), .phase(phase), .xfer_done(xfer_done), .cfg_done(cfg_done),
        .nstatus(nstatus), .dclk_done(dclk_done), .busy(busy), .done(done),
        .err(err), .cfg_wide(cfg_wide), .cd_ratio(cd_ratio), .nce(nce),
        .drive_en(drive_en), .nconfig_pull(nconfig_pull), .data_en(data_en),
        .irq_clear(irq_clear), .dclk_req(dclk_req), .dclk_cnt(dclk_cnt));

    // Fabric, mover and clock-generator stub; stall withholds one answer.
    always @(negedge clk) begin
        if (!rst_n) begin
            phase <= 3'd0; xfer_done <= 1'b0; dclk_done <= 1'b0;
        end else begin
            xfer_done <= data_en && !xfer_done && stall != 5;
            dclk_done <= dclk_req && !dclk_done &&
                         !(stall == 6 && dclk_cnt == DW'(IP)) &&
                         !(stall == 8 && dclk_cnt == DW'(UP));
            if (!drive_en) phase <= 3'd0;
            else if (nconfig_pull) begin
                if (stall != 2) phase <= 3'd1;
            end else if (phase == 3'd1) begin
                if (stall != 3) phase <= 3'd2;
            end else if (dclk_req && !dclk_done && dclk_cnt == DW'(IP)
                         && stall != 6 && stall != 7)
                phase <= init_user ? 3'd4 : 3'd3;
            else if (dclk_req && !dclk_done && dclk_cnt == DW'(UP)
                     && stall != 8 && stall != 9)
                phase <= 3'd4;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Results of one run, filled in by run().
    int  r_code, r_busy, t_nce, t_drv, t_pull, t_irq, t_data, r_c1, r_c2, r_irqv;
    bit  r_wide, r_any, r_rel;
    logic [1:0] r_ratio;

    task automatic run(input int st, input logic [3:0] m, input logic [AW-1:0] a,
                       input bit cd, input bit ns, input bit iu, input bit poke);
        stall = st; init_user = iu; cfg_done = cd; nstatus = ns;
        r_code = -1; r_busy = 0; t_nce = -1; t_drv = -1; t_pull = -1;
        t_irq = -1; t_data = -1; r_c1 = -1; r_c2 = -1; r_irqv = 0;
        r_any = 1'b0; r_rel = 1'b0; r_wide = 1'b0; r_ratio = 2'd0;
        @(negedge clk);
        start = 1'b1; start_addr = a; msel = m;
        for (int t = 0; t < 1000; t++) begin
            @(negedge clk);
            start = (poke && t == 10);
            start_addr = (poke && t == 10) ? AW'(1) : a;
            msel = (poke && t == 10) ? ~m : m;
            r_busy += busy;
            r_any |= !nce || drive_en || nconfig_pull || data_en || dclk_req || (irq_clear != 0);
            if (busy) begin r_wide = cfg_wide; r_ratio = cd_ratio; end
            if (!nce && t_nce < 0) t_nce = t;
            if (drive_en && t_drv < 0) t_drv = t;
            if (nconfig_pull && t_pull < 0) t_pull = t;
            if (irq_clear != 0 && t_irq < 0) begin t_irq = t; r_irqv = int'(irq_clear); end
            if (data_en && t_data < 0) t_data = t;
            if (dclk_req && r_c1 < 0) r_c1 = int'(dclk_cnt);
            if (dclk_req) r_c2 = int'(dclk_cnt);
            if (done) begin
                r_code = int'(err);
                r_rel = nce && !drive_en && !nconfig_pull && !data_en && !dclk_req && !busy;
                break;
            end
        end
        start = 1'b0;
        @(negedge clk);
        check(!done, "R11 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        cfg_done = 1'b1; nstatus = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check(!busy && !done && err == 0 && nce && !drive_en && !nconfig_pull &&
              !data_en && irq_clear == 0 && !dclk_req, "R13 idle after reset",
              int'({busy, done, err, nce, drive_en, nconfig_pull, data_en, dclk_req}), 8'h10);

        // Sweep all mode-select values through a full run (R1, R2, R3, R5, R6, R8, R9)
        for (int m = 0; m < 16; m++) begin
            int exp_r;
            run(0, 4'(m), AW'(m * 4), 1'b1, 1'b1, 1'b0, 1'b0);
            if (m[3]) exp_r = (m % 4 == 1) ? 2 : (m % 4 == 2) ? 3 : 0;
            else      exp_r = (m % 4 == 1) ? 1 : (m % 4 == 2) ? 2 : 0;
            check(r_code == 0, "R9 success code", r_code, 0);
            check(r_rel, "R9 drive released at done", int'(r_rel), 1);
            check(r_wide == m[3], "R1 width", int'(r_wide), m / 8);
            check(int'(r_ratio) == exp_r, m[3] ? "R2 wide ratio" : "R3 narrow ratio",
                  int'(r_ratio), exp_r);
            check(t_nce >= 0 && t_drv == t_nce + 1 && t_pull == t_drv + 1,
                  "R5 enable order", t_pull - t_nce, 2);
            check(t_data == t_irq + 1 && r_irqv == 12'hFFF, "R6 clear then data",
                  r_irqv, 12'hFFF);
            check(r_c1 == IP, "R8 first burst count", r_c1, IP);
            check(r_c2 == UP, "R9 second burst count", r_c2, UP);
        end

        // R4 misaligned addresses
        for (int lo = 1; lo < 4; lo++) begin
            run(0, 4'd0, AW'(8 + lo), 1'b1, 1'b1, 1'b0, 1'b0);
            check(r_code == 1, "R4 alignment code", r_code, 1);
            check(r_busy == 0 && !r_any, "R4 nothing driven", r_busy + int'(r_any), 0);
        end

        // R10 timeouts, each with its own code; R11 outputs released
        run(2, 4'd0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
        check(r_code == 2, "R10 reset timeout code", r_code, 2);
        check(r_busy == TO + 2, "R10 reset timeout length", r_busy, TO + 2);
        check(r_rel, "R11 released on error", int'(r_rel), 1);
        for (int s = 3; s <= 9; s++) begin
            if (s == 4) continue;
            run(s, 4'd9, '0, 1'b1, 1'b1, 1'b0, 1'b0);
            check(r_code == s, "R10 timeout code", r_code, s);
            check(r_rel, "R11 released on error", int'(r_rel), 1);
        end

        // R11 error code holds while idle
        run(3, 4'd0, '0, 1'b1, 1'b1, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        check(err == 3 && !busy, "R11 err holds", int'(err), 3);

        // R7 status check after transfer
        run(0, 4'd0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
        check(r_code == 4, "R7 neither line high", r_code, 4);
        check(r_c1 < 0, "R7 no burst after error", r_c1, -1);
        run(0, 4'd0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
        check(r_code == 0, "R7 config-done alone", r_code, 0);
        run(0, 4'd0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
        check(r_code == 0, "R7 status alone", r_code, 0);

        // R8 init wait also leaves on user mode
        run(0, 4'd0, '0, 1'b1, 1'b1, 1'b1, 1'b0);
        check(r_code == 0, "R8 user mode ends init wait", r_code, 0);

        // R12 start while busy is ignored
        run(0, 4'd8, '0, 1'b1, 1'b1, 1'b0, 1'b1);
        check(r_code == 0, "R12 restart ignored", r_code, 0);
        check(r_wide == 1'b1 && r_ratio == 2'd0, "R12 mode unchanged", int'(r_ratio), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule